// File: doc/BRIEF.md
# Load-switch SPI command core with frame watchdog

This block is the digital control core of a five-channel load switch. A host sends 16-bit command words over an SPI slave link. Each word carries a 5-bit register address in its top bits and data below it. The core decodes the address and updates the matching configuration or channel-control register. At one address, a data bit picks which of two registers receives the data.

Bit 10 of every accepted word feeds a watchdog. The host must flip that bit from word to word, and it must do so before a timeout counted in system clocks runs out. If the timeout expires, the core enters fail mode. In fail mode every register is held at zero and ordinary writes are ignored. A single word with bit 10 set brings the core back out of fail mode.

Each channel also has a "skip the high over-current phase" flag. This flag clears itself in three cases: when its channel is switched off, when a thermal or over-current fault is reported on that channel, and when an under-voltage fault is reported, which clears every channel at once.

Top module: `lsw_ctrl_core`

## Requirements
- R1: The SPI link uses mode 0 and sends the MSB first. A word is committed on the rising edge of chip select. Bits 15..11 are the address and bits 10..0 are the data.
- R2: A word is committed only when exactly 16 clock edges were received while chip select was low. Any other word changes no register and does not count as a watchdog feed.
- R3: A committed word feeds the watchdog when its bit 10 differs from that bit in the last word that fed it. After reset the reference value is 0. Once WD_TIMEOUT system clocks pass without a feed, `fail_mode` goes to 1.
- R4: While `fail_mode` is 1, every register output is 0 and committed words change nothing, with one exception given in R5. After reset, all outputs are 0.
- R5: A committed word with bit 10 = 1 clears `fail_mode` and sets the watchdog reference to 1. That word writes no register.
- R6: Address 00000 is the setup register. Its fields are:
  - bits 1..0: `stat_sel`;
  - bits 4..2: `sense_sel` (000 = none, 001..101 = outputs 1..5, 110 = external switch, 111 = temperature);
  - bit 5: `bulb_prof`;
  - bit 6: `sync_en`;
  - bit 7: `ext4_en`.
- R7: At address 00010, bit 9 = 0 writes bits 4..0 into `prescale_en`, and bit 9 = 1 writes bits 4..0 into `slew_fast`. Bit i maps to output i+1, and the other register keeps its value.
- R8: Address 00011 writes bits 4..0 into `skip_oc`. Addresses 01001 to 01101 control outputs 1 to 5, and data bit 0 of such a word sets that output's `ch_on`.
- R9: `skip_oc[i]` clears when a control word turns `ch_on[i]` from 1 to 0, and in any cycle where `ot_flt[i]` or `oc_flt[i]` is high. A clear wins over a write in the same cycle.
- R10: Any cycle with `uv_flt` high clears all `skip_oc` bits.
- R11: `sync_pulse` goes high for exactly one clock for each committed word that `sync_en` allows. The value of `sync_en` that applies is the one before that word. No pulse is produced in fail mode.
- R12: A committed word at any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data in |
| ot_flt | input | 5 | Per-channel over-temperature fault |
| oc_flt | input | 5 | Per-channel over-current fault |
| uv_flt | input | 1 | Supply under-voltage fault |
| fail_mode | output | 1 | Watchdog fail mode active |
| sync_pulse | output | 1 | One-clock synchronisation pulse |
| stat_sel | output | 2 | Status word chosen for the next reply |
| sense_sel | output | 3 | Sense multiplexer selector |
| bulb_prof | output | 1 | Channel 2 load profile select |
| ext4_en | output | 1 | External pin controls output 4 |
| prescale_en | output | 5 | Per-output PWM prescaler enable |
| slew_fast | output | 5 | Per-output fast slew enable |
| skip_oc | output | 5 | Per-output skip-high-over-current flags |
| ch_on | output | 5 | Per-output on/off control |

## Verification
Some rules are checked by the assertions on every cycle:
- the wipe of all registers while in fail mode;
- that only a bit-10-set word ends fail mode;
- that a feeding word never ends in failure;
- the automatic clears of `skip_oc` on channel turn-off and under-voltage;
- that words at unknown addresses leave the registers alone;
- the single-cycle commit pulse.

Other behaviour only the bench scenarios can show. These include the field layout of each register, the bank choice at address 00010, and the rejection of 15- and 17-bit words. They also include the failure of the watchdog when repeated words carry an unchanged bit 10, and the exact count of sync pulses around a word that turns synchronisation off.

// File: rtl/lsw_pkg.sv
// Shared constants for the load-switch control core: frame layout,
// register addresses and data-bit positions that the decoder relies on.
package lsw_pkg;
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 5;
    localparam int WD_POS   = 10;
    localparam int BANK_POS = 9;
    localparam int ON_POS   = 0;
    localparam int INIT_W   = 8;
    localparam logic [ADDR_W-1:0] ADR_SETUP   = 5'b00000;
    localparam logic [ADDR_W-1:0] ADR_PRESLEW = 5'b00010;
    localparam logic [ADDR_W-1:0] ADR_SKIPOC  = 5'b00011;
    localparam logic [ADDR_W-1:0] ADR_CTRL1   = 5'b01001;
endpackage

// File: rtl/lsw_spi_rx.sv
// SPI mode-0 receiver (MSB first) sampled in the system clock domain.
// Assumes SCLK is slower than clk/4 so that edges survive the synchronisers.
// Emits frame_vld for one clock on a chip-select rise that followed exactly
// FRAME_W clock edges; every other frame is dropped.
module lsw_spi_rx #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame_data
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    logic [2:0]         sck_s;
    logic [2:0]         cs_s;
    logic [1:0]         mosi_s;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic               sck_rise;
    logic               cs_rise;

    assign sck_rise = sck_s[1] & ~sck_s[2];
    assign cs_rise  = cs_s[1] & ~cs_s[2];

    // Bring the three SPI pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s  <= 3'b000;
            cs_s   <= 3'b111;
            mosi_s <= 2'b00;
        end else begin
            sck_s  <= {sck_s[1:0], sclk};
            cs_s   <= {cs_s[1:0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    // Shift data on each SCLK rise and count edges, saturating past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (cs_s[1]) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            shreg <= {shreg[FRAME_W-2:0], mosi_s[1]};
            if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Commit a frame on chip-select rise when the edge count is exact.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_vld  <= 1'b0;
            frame_data <= '0;
        end else begin
            frame_vld <= cs_rise && (bit_cnt == CNT_FULL);
            if (cs_rise) frame_data <= shreg;
        end
    end

    // R1: a commit lasts exactly one clock
    a_r1_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);
endmodule

// File: rtl/lsw_wd.sv
// Frame watchdog: a committed frame whose watchdog bit differs from the last
// feeding frame restarts the timer; TIMEOUT idle clocks set fail. Only a frame
// with the watchdog bit set leaves fail. Assumes TIMEOUT >= 2.
module lsw_wd #(
    parameter int TIMEOUT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_vld,
    input  logic wd_bit,
    output logic fail
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;
    logic          ref_bit;
    logic          feed;

    assign feed = frame_vld && (wd_bit != ref_bit);

    // Run the timeout counter and the fail state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            ref_bit <= 1'b0;
            fail    <= 1'b0;
        end else if (fail) begin
            if (frame_vld && wd_bit) begin
                fail    <= 1'b0;
                cnt     <= '0;
                ref_bit <= 1'b1;
            end
        end else if (feed) begin
            cnt     <= '0;
            ref_bit <= wd_bit;
        end else if (cnt == LAST) begin
            fail <= 1'b1;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: leaving fail needs a committed frame with the watchdog bit set
    a_r5_exit_needs_wd1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail) |-> $past(frame_vld && wd_bit));
    // R3: a feeding frame never leads straight into fail
    a_r3_feed_keeps_alive: assert property (@(posedge clk) disable iff (!rst_n)
        (!fail && feed) |=> !fail);
    // R4: fail holds until an exit frame
    a_r4_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(frame_vld && wd_bit)) |=> fail);
endmodule

// File: rtl/lsw_regs.sv
// Register bank of the load-switch core: decodes committed frames, keeps the
// setup, prescaler, slew, skip-over-current and channel registers, applies
// the self-clearing rules and forms the sync pulse. Held at zero while fail.
// Assumes N_OUT <= 8 so per-output fields fit under the bank-select bit.
module lsw_regs import lsw_pkg::*; #(
    parameter int N_OUT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_vld,
    input  logic [FRAME_W-1:0] frame_data,
    input  logic               fail,
    input  logic [N_OUT-1:0]   ot_flt,
    input  logic [N_OUT-1:0]   oc_flt,
    input  logic               uv_flt,
    output logic [1:0]         stat_sel,
    output logic [2:0]         sense_sel,
    output logic               bulb_prof,
    output logic               sync_en,
    output logic               ext4_en,
    output logic [N_OUT-1:0]   prescale_en,
    output logic [N_OUT-1:0]   slew_fast,
    output logic [N_OUT-1:0]   skip_oc,
    output logic [N_OUT-1:0]   ch_on,
    output logic               sync_pulse
);
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [INIT_W-1:0] setup_q;
    logic [N_OUT-1:0]  ctrl_hit;
    logic [N_OUT-1:0]  off_evt;
    logic [N_OUT-1:0]  on_nx;
    logic [N_OUT-1:0]  skip_nx;
    logic [N_OUT-1:0]  skip_clr;
    logic              known_adr;
    logic [1:0]        unused_bits;

    assign wr          = frame_vld && !fail;
    assign addr        = frame_data[FRAME_W-1 -: ADDR_W];
    assign unused_bits = {frame_data[WD_POS], frame_data[8]};
    assign stat_sel    = setup_q[1:0];
    assign sense_sel   = setup_q[4:2];
    assign bulb_prof   = setup_q[5];
    assign sync_en     = setup_q[6];
    assign ext4_en     = setup_q[7];
    assign known_adr   = (addr == ADR_SETUP) || (addr == ADR_PRESLEW) ||
                         (addr == ADR_SKIPOC) || (|ctrl_hit);

    // Per-channel control decode and turn-off detection.
    for (genvar i = 0; i < N_OUT; i++) begin : g_ch
        assign ctrl_hit[i] = wr && (addr == ADR_CTRL1 + ADDR_W'(i));
        assign off_evt[i]  = ctrl_hit[i] && ch_on[i] && !frame_data[ON_POS];

        // R9: a channel turning off leaves its skip flag cleared
        a_r9_off_clears_skip: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_on[i]) |-> !skip_oc[i]);
    end

    assign skip_clr = off_evt | ot_flt | oc_flt | {N_OUT{uv_flt}};

    // Next channel on/off state from control writes.
    always_comb begin
        on_nx = ch_on;
        for (int i = 0; i < N_OUT; i++)
            if (ctrl_hit[i]) on_nx[i] = frame_data[ON_POS];
    end

    // Next skip flags: write first, then the clear conditions win.
    always_comb begin
        skip_nx = skip_oc;
        if (wr && addr == ADR_SKIPOC) skip_nx = frame_data[N_OUT-1:0];
        skip_nx = skip_nx & ~skip_clr;
    end

    // Setup register and prescaler/slew bank.
    always_ff @(posedge clk) begin
        if (!rst_n || fail) begin
            setup_q     <= '0;
            prescale_en <= '0;
            slew_fast   <= '0;
        end else if (wr) begin
            if (addr == ADR_SETUP) setup_q <= frame_data[INIT_W-1:0];
            if (addr == ADR_PRESLEW && !frame_data[BANK_POS])
                prescale_en <= frame_data[N_OUT-1:0];
            if (addr == ADR_PRESLEW && frame_data[BANK_POS])
                slew_fast <= frame_data[N_OUT-1:0];
        end
    end

    // Channel state, skip flags and the sync pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || fail) begin
            ch_on      <= '0;
            skip_oc    <= '0;
            sync_pulse <= 1'b0;
        end else begin
            ch_on      <= on_nx;
            skip_oc    <= skip_nx;
            sync_pulse <= wr && sync_en;
        end
    end

    // R4: fail wipes every register by the next clock
    a_r4_wipe_in_fail: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (setup_q == '0 && prescale_en == '0 && slew_fast == '0 &&
                  skip_oc == '0 && ch_on == '0 && !sync_pulse));
    // R10: under-voltage clears every skip flag
    a_r10_uv_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flt |=> (skip_oc == '0));
    // R11: a sync pulse follows an accepted frame
    a_r11_sync_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> $past(frame_vld && !fail));
    // R12: unknown addresses leave the registers alone
    a_r12_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !known_adr) |=> ($stable(setup_q) && $stable(prescale_en) &&
                                $stable(slew_fast) && $stable(ch_on)));
endmodule

// File: rtl/lsw_ctrl_core.sv
// Top of the load-switch control core: SPI receiver, frame watchdog and
// register bank. Assumes SPI pins are asynchronous to clk and slow.
module lsw_ctrl_core import lsw_pkg::*; #(
    parameter int N_OUT      = 5,
    parameter int WD_TIMEOUT = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    input  logic [N_OUT-1:0] ot_flt,
    input  logic [N_OUT-1:0] oc_flt,
    input  logic             uv_flt,
    output logic             fail_mode,
    output logic             sync_pulse,
    output logic [1:0]       stat_sel,
    output logic [2:0]       sense_sel,
    output logic             bulb_prof,
    output logic             ext4_en,
    output logic [N_OUT-1:0] prescale_en,
    output logic [N_OUT-1:0] slew_fast,
    output logic [N_OUT-1:0] skip_oc,
    output logic [N_OUT-1:0] ch_on
);
    logic               frame_vld;
    logic [FRAME_W-1:0] frame_data;
    logic               sync_en;

    lsw_spi_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (spi_sclk),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .frame_vld  (frame_vld),
        .frame_data (frame_data)
    );

    lsw_wd #(.TIMEOUT(WD_TIMEOUT)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .wd_bit    (frame_data[WD_POS]),
        .fail      (fail_mode)
    );

    lsw_regs #(.N_OUT(N_OUT)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_vld   (frame_vld),
        .frame_data  (frame_data),
        .fail        (fail_mode),
        .ot_flt      (ot_flt),
        .oc_flt      (oc_flt),
        .uv_flt      (uv_flt),
        .stat_sel    (stat_sel),
        .sense_sel   (sense_sel),
        .bulb_prof   (bulb_prof),
        .sync_en     (sync_en),
        .ext4_en     (ext4_en),
        .prescale_en (prescale_en),
        .slew_fast   (slew_fast),
        .skip_oc     (skip_oc),
        .ch_on       (ch_on),
        .sync_pulse  (sync_pulse)
    );
endmodule

// File: tb/lsw_ctrl_core_tb.sv
// Bench: behavioural model updated from the bench's own stimulus, compared
// one ns after every rising edge outside short settle windows.
module lsw_ctrl_core_tb;
    localparam int TO     = 600;
    localparam int N      = 5;
    localparam int MARGIN = 12;

    logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0, uv = 0;
    logic [N-1:0] ot = '0, oc = '0;
    logic fail_mode, sync_pulse, bulb_prof, ext4_en;
    logic [1:0] stat_sel;
    logic [2:0] sense_sel;
    logic [N-1:0] prescale_en, slew_fast, skip_oc, ch_on;

    always #2 clk = ~clk;

    lsw_ctrl_core #(.N_OUT(N), .WD_TIMEOUT(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .ot_flt(ot), .oc_flt(oc), .uv_flt(uv), .fail_mode(fail_mode),
        .sync_pulse(sync_pulse), .stat_sel(stat_sel), .sense_sel(sense_sel),
        .bulb_prof(bulb_prof), .ext4_en(ext4_en), .prescale_en(prescale_en),
        .slew_fast(slew_fast), .skip_oc(skip_oc), .ch_on(ch_on)
    );

    int n_chk = 0, n_fail = 0;
    bit mfail = 0, mref = 0, busy = 0;
    int mcnt = 0, sync_seen = 0;
    bit [1:0] m_stat;
    bit [2:0] m_sense;
    bit m_prof, m_sync, m_ext;
    bit [N-1:0] m_pre, m_slew, m_skip, m_on;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        m_stat = 0; m_sense = 0; m_prof = 0; m_sync = 0; m_ext = 0;
        m_pre = 0; m_slew = 0; m_skip = 0; m_on = 0;
    endtask

    task automatic compare_all();
        chk("R4 fail_mode", fail_mode, mfail);
        chk("R6 stat_sel", stat_sel, m_stat);
        chk("R6 sense_sel", sense_sel, m_sense);
        chk("R6 bulb_prof", bulb_prof, m_prof);
        chk("R6 ext4_en", ext4_en, m_ext);
        chk("R7 prescale_en", prescale_en, m_pre);
        chk("R7 slew_fast", slew_fast, m_slew);
        chk("R9 skip_oc", skip_oc, m_skip);
        chk("R8 ch_on", ch_on, m_on);
        chk("R11 no stray sync", sync_pulse, 1'b0);
    endtask

    // Per-cycle comparison and model watchdog.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (!mfail) mcnt++;
            if (!mfail && mcnt >= TO + MARGIN) begin
                mfail = 1;
                clear_model();
            end
            if (busy) begin
                if (sync_pulse) sync_seen++;
            end else if (mfail || mcnt < TO - MARGIN) begin
                compare_all();
            end
        end
    end

    task automatic apply(input logic [15:0] w);
        int idx;
        if (mfail) begin
            if (w[10]) begin mfail = 0; mcnt = 0; mref = 1; end
            return;
        end
        if (w[10] != mref) begin mcnt = 0; mref = w[10]; end
        case (w[15:11])
            5'd0: {m_ext, m_sync, m_prof, m_sense, m_stat} = w[7:0];
            5'd2: if (w[9]) m_slew = w[4:0]; else m_pre = w[4:0];
            5'd3: m_skip = w[4:0];
            5'd9, 5'd10, 5'd11, 5'd12, 5'd13: begin
                idx = int'(w[15:11]) - 9;
                if (m_on[idx] && !w[0]) m_skip[idx] = 0;
                m_on[idx] = w[0];
            end
            default: ;
        endcase
    endtask

    // Drive one SPI frame of nb clocks; wd is frame bit 10.
    task automatic send(input logic [4:0] a, input logic wd, input logic [9:0] d, input int nb);
        logic [15:0] w;
        bit exp_sync;
        w = {a, wd, d};
        @(negedge clk) cs_n = 0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            mosi = w[15 - (i % 16)];
            repeat (4) @(negedge clk);
            sclk = 1;
            repeat (4) @(negedge clk);
            sclk = 0;
        end
        repeat (4) @(negedge clk);
        busy = 1; sync_seen = 0;
        exp_sync = (nb == 16) && !mfail && m_sync;
        cs_n = 1;
        repeat (8) @(negedge clk);
        if (nb == 16) apply(w);
        chk("R11 sync pulse count", sync_seen, exp_sync ? 1 : 0);
        busy = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic sendt(input logic [4:0] a, input logic [9:0] d);
        send(a, ~mref, d, 16);
    endtask

    task automatic pulse_flt(input logic [N-1:0] o_t, input logic [N-1:0] o_c, input logic u);
        @(negedge clk);
        ot = o_t; oc = o_c; uv = u;
        if (!mfail) begin
            m_skip = m_skip & ~(o_t | o_c);
            if (u) m_skip = 0;
        end
        @(negedge clk);
        ot = '0; oc = '0; uv = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        clear_model();
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R4 reset fail_mode", fail_mode, 0);
        chk("R4 reset registers", {ch_on, skip_oc, prescale_en, slew_fast}, 0);

        // R1 R6: setup fields
        sendt(5'd0, 10'b00_1111_0110);
        chk("R6 setup sense_sel", sense_sel, 3'b101);
        chk("R1 setup stat_sel", stat_sel, 2'b10);
        // R7: bank select at 00010
        sendt(5'd2, 10'b00_0001_0101);
        sendt(5'd2, 10'b10_0000_1011);
        chk("R7 prescale kept", prescale_en, 5'b10101);
        chk("R7 slew written", slew_fast, 5'b01011);
        // R8: channels on, skip flags
        for (int i = 0; i < N; i++) sendt(5'(9 + i), 10'd1);
        chk("R8 all on", ch_on, 5'b11111);
        sendt(5'd3, 10'b1_1111);
        chk("R8 skip set", skip_oc, 5'b11111);
        // R9: turn-off and per-channel fault clears
        sendt(5'd10, 10'd0);
        chk("R9 off clears skip", skip_oc, 5'b11101);
        pulse_flt(5'b00001, 5'b10000, 0);
        chk("R9 fault clears skip", skip_oc, 5'b01100);
        // R10: under-voltage
        sendt(5'd3, 10'b1_1111);
        pulse_flt('0, '0, 1);
        chk("R10 uv clears all", skip_oc, 0);
        // R12: unknown addresses
        sendt(5'd7, 10'h3FF);
        sendt(5'd14, 10'h3FF);
        chk("R12 unknown ignored", {prescale_en, slew_fast, ch_on}, {5'b10101, 5'b01011, 5'b11101});
        // R2: 15- and 17-clock frames dropped
        send(5'd0, ~mref, 10'h000, 15);
        send(5'd0, ~mref, 10'h000, 17);
        chk("R2 short/long frame ignored", sense_sel, 3'b101);
        // R11: disabling sync; this frame still pulses, next one not
        sendt(5'd0, 10'b00_1011_0110);
        sendt(5'd2, 10'b00_0000_0001);
        chk("R11 sync disabled", sync_pulse, 0);
        // R3: toggle, then unchanged-bit frames and a dropped toggle
        sendt(5'd2, 10'b00_0000_0011);
        send(5'd2, mref, 10'h000, 16);
        send(5'd2, ~mref, 10'h000, 15);
        send(5'd2, mref, 10'h000, 16);
        repeat (300) @(negedge clk);
        chk("R3 watchdog expired", fail_mode, 1);
        chk("R4 wiped", {ch_on, prescale_en, sense_sel}, 0);
        // R4: writes ignored in fail
        send(5'd0, 1'b0, 10'b00_0001_1100, 16);
        chk("R4 write ignored", {fail_mode, sense_sel}, 4'b1000);
        // R5: exit frame does not write
        send(5'd0, 1'b1, 10'b00_0001_1100, 16);
        chk("R5 fail left", fail_mode, 0);
        chk("R5 exit frame no write", sense_sel, 0);
        send(5'd0, 1'b0, 10'b00_0001_1100, 16);
        chk("R5 reference now 1", {fail_mode, sense_sel}, 4'b0111);
        repeat (10) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule